// File: doc/BRIEF.md
# Receive flow-hash queue selector

This block steers every received packet to one of eight receive queues so that all packets of a single session share a queue, and their relative order survives multi-core processing. It takes an already parsed packet descriptor, with layer-3 and layer-4 type flags, source and destination addresses and layer-4 ports. From these it builds a hash input whose content depends on the packet's class. It then runs a keyed Toeplitz-style hash over that input, one byte per clock cycle.

The low bits of the 32-bit hash index a programmable 128-entry indirection table. The entry found there is the queue number, and the block reports it together with the hash on a single-cycle done strobe. Each class can have its hash switched off. A switched-off class, and any packet outside the four hashed classes, gets a hash of zero and so lands in the queue held in table entry 0.

The hash key, the class enables and the table contents are all set through a plain single-cycle register write port.

Top module: `rfq_selector`

## Requirements
- R1: Class is chosen in this priority order: an IPv4 packet (`pkt_v4` set; IPv4 wins when both layer-3 flags are set) or an IPv6 packet with `pkt_tcp` set is TCP. One of these with `pkt_udp` set and `pkt_tcp` clear is UDP. Any remaining IPv4 packet is other-IPv4 and any remaining IPv6 packet is other-IPv6. A packet with neither layer-3 flag is unhashed.
- R2: TCP and UDP hash the byte string source address, destination address, source port, destination port, protocol number (6 for TCP, 17 for UDP), each field most significant byte first. That is 13 bytes for IPv4, using the low 32 bits of each address field, and 37 bytes for IPv6.
- R3: Other-IPv4 hashes only the two 32-bit addresses (8 bytes). Other-IPv6 hashes only the two 128-bit addresses (32 bytes).
- R4: For input bit i, counted from the first byte's MSB, a set bit XORs into the hash the 32 key bits starting at key bit (i mod 320), wrapping circularly. Key bit 0 is bit 31 of key word 0.
- R5: When the class enable is clear, or the packet is unhashed, the reported hash is 0 and the queue is table entry 0. Enable bits are: bit 0 TCP, bit 1 UDP, bit 2 other-IPv4, bit 3 other-IPv6.
- R6: The reported queue is the table entry indexed by hash bits [6:0].
- R7: A start accepted on clock edge E0 gives a one-cycle `sel_done` pulse after edge E(N+1), where N is the hashed byte count. A zero-hash packet gives the pulse after edge E1.
- R8: A start raised while a packet is still in progress is ignored: it produces no extra done pulse and does not change the result.
- R9: After reset, `sel_done`, `sel_queue` and `sel_hash` are 0, the key and the enables are 0, and table entry i holds i mod 8.
- R10: A table write sampled on the same edge as the lookup (the edge that raises `sel_done`) is not seen by that packet. A write sampled one edge earlier is seen.
- R11: Address map: 0 to 127 write table entries (data bits [2:0]), 128 to 137 write key words 0 to 9, and 138 writes the enables (data bits [3:0]). Writes to other addresses change nothing.
- R12: Packets with identical hash inputs always get the same hash and queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Descriptor valid; accepted when idle |
| pkt_v4 | input | 1 | Layer-3 is IPv4 |
| pkt_v6 | input | 1 | Layer-3 is IPv6 |
| pkt_tcp | input | 1 | Layer-4 is TCP |
| pkt_udp | input | 1 | Layer-4 is UDP |
| pkt_src | input | 128 | Source address (IPv4 in bits 31:0) |
| pkt_dst | input | 128 | Destination address (IPv4 in bits 31:0) |
| pkt_sport | input | 16 | Source port |
| pkt_dport | input | 16 | Destination port |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| sel_done | output | 1 | Result strobe, one cycle |
| sel_queue | output | 3 | Selected receive queue |
| sel_hash | output | 32 | Computed hash |

## Verification
Two functions can land on the same clock edge: a software write to the indirection table and the table read that closes a packet. The bench counts edges from the accepted start to place a write of the very entry that the packet's hash selects. It puts the write once on the lookup edge itself and once on the edge before. The first case must return the old queue and the second the new one. The same collision is also driven on entry 0 for a zero-hash packet, whose lookup comes straight after the start edge.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

   // Longest hash input: IPv6 5-tuple = 16 + 16 + 2 + 2 + 1 bytes
   localparam int MSG_BYTES = 37;

   localparam logic [7:0] PROTO_TCP = 8'd6;
   localparam logic [7:0] PROTO_UDP = 8'd17;

   typedef enum logic [2:0] {
      CLS_TCP  = 3'd0,
      CLS_UDP  = 3'd1,
      CLS_IP4  = 3'd2,
      CLS_IP6  = 3'd3,
      CLS_NONE = 3'd4
   } rfq_class_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HASH = 2'd1,
      ST_LOOK = 2'd2
   } rfq_state_e;

endpackage

// File: rtl/rfq_classify.sv
module rfq_classify
   import rfq_pkg::*;
#(
   parameter int MSG_BITS = MSG_BYTES * 8,
   parameter int LEN_W    = 6
) (
   input  logic                v4_i,
   input  logic                v6_i,
   input  logic                tcp_i,
   input  logic                udp_i,
   input  logic [127:0]        src_i,
   input  logic [127:0]        dst_i,
   input  logic [15:0]         sport_i,
   input  logic [15:0]         dport_i,
   input  logic [3:0]          class_en_i,
   output logic [MSG_BITS-1:0] msg_o,
   output logic [LEN_W-1:0]    len_o,
   output logic                hash_on_o
);

   generate
      if (MSG_BITS < 296) begin : g_bad_msg
         $error("rfq_classify: MSG_BITS too small for IPv6 5-tuple");
      end
      if ((1 << LEN_W) <= MSG_BITS / 8) begin : g_bad_len
         $error("rfq_classify: LEN_W cannot hold byte count");
      end
   endgenerate

   rfq_class_e cls;
   logic       has_l3;
   logic [7:0] proto;

   always_comb begin
      has_l3 = v4_i | v6_i;
      if (has_l3 && tcp_i)      cls = CLS_TCP;
      else if (has_l3 && udp_i) cls = CLS_UDP;
      else if (v4_i)            cls = CLS_IP4;
      else if (v6_i)            cls = CLS_IP6;
      else                      cls = CLS_NONE;
   end

   assign proto = (cls == CLS_TCP) ? PROTO_TCP : PROTO_UDP;

   always_comb begin
      msg_o = '0;
      len_o = '0;
      unique case (cls)
         CLS_TCP, CLS_UDP: begin
            if (v4_i) begin
               msg_o = {src_i[31:0], dst_i[31:0], sport_i, dport_i, proto,
                        {(MSG_BITS-104){1'b0}}};
               len_o = LEN_W'(13);
            end else begin
               msg_o = {src_i, dst_i, sport_i, dport_i, proto,
                        {(MSG_BITS-296){1'b0}}};
               len_o = LEN_W'(37);
            end
         end
         CLS_IP4: begin
            msg_o = {src_i[31:0], dst_i[31:0], {(MSG_BITS-64){1'b0}}};
            len_o = LEN_W'(8);
         end
         CLS_IP6: begin
            msg_o = {src_i, dst_i, {(MSG_BITS-256){1'b0}}};
            len_o = LEN_W'(32);
         end
         default: begin
            msg_o = '0;
            len_o = '0;
         end
      endcase
   end

   always_comb begin
      unique case (cls)
         CLS_TCP: hash_on_o = class_en_i[0];
         CLS_UDP: hash_on_o = class_en_i[1];
         CLS_IP4: hash_on_o = class_en_i[2];
         CLS_IP6: hash_on_o = class_en_i[3];
         default: hash_on_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rfq_toeplitz.sv
module rfq_toeplitz
   import rfq_pkg::*;
#(
   parameter int KEY_BITS = 320,
   parameter int HASH_W   = 32,
   parameter int MSG_BITS = MSG_BYTES * 8,
   parameter int LEN_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                hash_on_i,
   input  logic [MSG_BITS-1:0] msg_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic [KEY_BITS-1:0] key_i,
   output logic                lookup_o,
   output logic [HASH_W-1:0]   hash_o
);

   generate
      if (KEY_BITS < HASH_W + 8) begin : g_bad_key
         $error("rfq_toeplitz: key shorter than hash window plus one byte");
      end
      if (MSG_BITS % 8 != 0) begin : g_bad_msg
         $error("rfq_toeplitz: MSG_BITS must be whole bytes");
      end
   endgenerate

   rfq_state_e          st;
   logic [MSG_BITS-1:0] msg_q;
   logic [KEY_BITS-1:0] kreg;
   logic [LEN_W-1:0]    remain;
   logic [HASH_W-1:0]   acc;
   logic [HASH_W-1:0]   mix;
   logic [HASH_W-1:0]   term [8];

   // One key window per bit of the current byte, MSB first
   generate
      for (genvar j = 0; j < 8; j++) begin : g_bit
         assign term[j] = msg_q[MSG_BITS-1-j] ? kreg[KEY_BITS-1-j -: HASH_W] : '0;
      end
   endgenerate

   always_comb begin
      mix = '0;
      for (int j = 0; j < 8; j++) mix = mix ^ term[j];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         msg_q  <= '0;
         kreg   <= '0;
         remain <= '0;
         acc    <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  acc <= '0;
                  if (hash_on_i && len_i != '0) begin
                     msg_q  <= msg_i;
                     kreg   <= key_i;
                     remain <= len_i;
                     st     <= ST_HASH;
                  end else begin
                     st <= ST_LOOK;
                  end
               end
            end
            ST_HASH: begin
               acc    <= acc ^ mix;
               msg_q  <= msg_q << 8;
               kreg   <= {kreg[KEY_BITS-9:0], kreg[KEY_BITS-1 -: 8]};
               remain <= remain - LEN_W'(1);
               if (remain == LEN_W'(1)) st <= ST_LOOK;
            end
            ST_LOOK: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign lookup_o = (st == ST_LOOK);
   assign hash_o   = acc;

   p_bypass_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start_i && !(hash_on_i && len_i != '0))
      |=> (st == ST_LOOK && acc == '0));

   p_byte_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HASH && remain > LEN_W'(1))
      |=> (st == ST_HASH && remain == $past(remain) - LEN_W'(1)));

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HASH && start_i && remain > LEN_W'(1)) |=> st == ST_HASH);

endmodule

// File: rtl/rfq_indir_table.sv
module rfq_indir_table #(
   parameter int QUEUES = 8,
   parameter int IDX_W  = 7,
   parameter int DEPTH  = 1 << IDX_W,
   parameter int QW     = $clog2(QUEUES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] waddr_i,
   input  logic [QW-1:0]    wdata_i,
   input  logic             rd_en_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [QW-1:0]    q_o
);

   generate
      if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
         $error("rfq_indir_table: DEPTH must equal 2**IDX_W");
      end
      if (QUEUES < 2) begin : g_bad_q
         $error("rfq_indir_table: need at least two queues");
      end
   endgenerate

   logic [QW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= QW'(i % QUEUES);
      end else if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   // Read at the lookup edge sees only writes from earlier edges
   always_ff @(posedge clk) begin
      if (!rst_n)       q_o <= '0;
      else if (rd_en_i) q_o <= mem[rd_idx_i];
   end

endmodule

// File: rtl/rfq_selector.sv
module rfq_selector
   import rfq_pkg::*;
#(
   parameter int QUEUES    = 8,
   parameter int TBL_IDX_W = 7,
   parameter int HASH_W    = 32,
   parameter int KEY_BYTES = 40,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   localparam int QW        = $clog2(QUEUES),
   localparam int TBL_DEPTH = 1 << TBL_IDX_W,
   localparam int KEY_BITS  = KEY_BYTES * 8,
   localparam int KEY_WORDS = KEY_BITS / DATA_W,
   localparam int KEY_BASE  = TBL_DEPTH,
   localparam int EN_ADDR   = KEY_BASE + KEY_WORDS,
   localparam int MSG_BITS  = MSG_BYTES * 8,
   localparam int LEN_W     = $clog2(MSG_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_start,
   input  logic              pkt_v4,
   input  logic              pkt_v6,
   input  logic              pkt_tcp,
   input  logic              pkt_udp,
   input  logic [127:0]      pkt_src,
   input  logic [127:0]      pkt_dst,
   input  logic [15:0]       pkt_sport,
   input  logic [15:0]       pkt_dport,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              sel_done,
   output logic [QW-1:0]     sel_queue,
   output logic [HASH_W-1:0] sel_hash
);

   generate
      if (KEY_BITS % DATA_W != 0) begin : g_bad_kw
         $error("rfq_selector: key must be whole data words");
      end
      if (EN_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("rfq_selector: register map exceeds address space");
      end
      if (TBL_IDX_W > HASH_W || ADDR_W <= TBL_IDX_W) begin : g_bad_idx
         $error("rfq_selector: table index width inconsistent");
      end
      if (DATA_W < 4 || DATA_W < QW) begin : g_bad_dw
         $error("rfq_selector: data word too narrow");
      end
   endgenerate

   // ---------------- configuration registers ----------------
   logic [DATA_W-1:0]   key_w [KEY_WORDS];
   logic [KEY_BITS-1:0] key_q;
   logic [3:0]          en_q;

   generate
      for (genvar w = 0; w < KEY_WORDS; w++) begin : g_key
         always_ff @(posedge clk) begin
            if (!rst_n) key_w[w] <= '0;
            else if (cfg_we && int'(cfg_addr) == KEY_BASE + w) key_w[w] <= cfg_wdata;
         end
         assign key_q[KEY_BITS-1-w*DATA_W -: DATA_W] = key_w[w];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else if (cfg_we && int'(cfg_addr) == EN_ADDR) en_q <= cfg_wdata[3:0];
   end

   // ---------------- datapath ----------------
   logic [MSG_BITS-1:0] msg;
   logic [LEN_W-1:0]    len;
   logic                hash_on;
   logic                lookup;
   logic [HASH_W-1:0]   acc;
   logic                tbl_we;

   rfq_classify #(.MSG_BITS(MSG_BITS), .LEN_W(LEN_W)) u_cls (
      .v4_i(pkt_v4), .v6_i(pkt_v6), .tcp_i(pkt_tcp), .udp_i(pkt_udp),
      .src_i(pkt_src), .dst_i(pkt_dst), .sport_i(pkt_sport), .dport_i(pkt_dport),
      .class_en_i(en_q), .msg_o(msg), .len_o(len), .hash_on_o(hash_on)
   );

   rfq_toeplitz #(.KEY_BITS(KEY_BITS), .HASH_W(HASH_W), .MSG_BITS(MSG_BITS),
                  .LEN_W(LEN_W)) u_hash (
      .clk(clk), .rst_n(rst_n), .start_i(pkt_start), .hash_on_i(hash_on),
      .msg_i(msg), .len_i(len), .key_i(key_q),
      .lookup_o(lookup), .hash_o(acc)
   );

   assign tbl_we = cfg_we && (int'(cfg_addr) < TBL_DEPTH);

   rfq_indir_table #(.QUEUES(QUEUES), .IDX_W(TBL_IDX_W), .DEPTH(TBL_DEPTH),
                     .QW(QW)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we_i(tbl_we),
      .waddr_i(cfg_addr[TBL_IDX_W-1:0]), .wdata_i(cfg_wdata[QW-1:0]),
      .rd_en_i(lookup), .rd_idx_i(acc[TBL_IDX_W-1:0]), .q_o(sel_queue)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_done <= 1'b0;
         sel_hash <= '0;
      end else begin
         sel_done <= lookup;
         if (lookup) sel_hash <= acc;
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_done |=> !sel_done);

   p_lookup_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lookup |=> sel_done);

   p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) > EN_ADDR) |=> ($stable(key_q) && $stable(en_q)));

endmodule

// File: tb/rfq_selector_tb_top.sv
module rfq_selector_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pkt_start = 1'b0;
   logic         pkt_v4 = 1'b0, pkt_v6 = 1'b0, pkt_tcp = 1'b0, pkt_udp = 1'b0;
   logic [127:0] pkt_src = '0, pkt_dst = '0;
   logic [15:0]  pkt_sport = '0, pkt_dport = '0;
   logic         cfg_we = 1'b0;
   logic [7:0]   cfg_addr = '0;
   logic [31:0]  cfg_wdata = '0;
   logic         sel_done;
   logic [2:0]   sel_queue;
   logic [31:0]  sel_hash;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [319:0] tb_key = '0;
   logic [3:0]   tb_en = '0;
   logic [2:0]   tb_tbl [128];

   logic [31:0] got_hash;
   logic [2:0]  got_q;
   int          got_lat;
   int          got_cnt;

   always #10 clk = ~clk;

   rfq_selector dut_i (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
      .pkt_v4(pkt_v4), .pkt_v6(pkt_v6), .pkt_tcp(pkt_tcp), .pkt_udp(pkt_udp),
      .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pkt_sport(pkt_sport), .pkt_dport(pkt_dport),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sel_done(sel_done), .sel_queue(sel_queue), .sel_hash(sel_hash)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------- reference model from the requirements ----------
   function automatic int ref_class();
      bit l3 = pkt_v4 | pkt_v6;
      if (l3 && pkt_tcp) return 0;
      if (l3 && pkt_udp) return 1;
      if (pkt_v4) return 2;
      if (pkt_v6) return 3;
      return 4;
   endfunction

   function automatic logic [31:0] ref_hash(output int nbytes);
      logic [295:0] m;
      logic [31:0]  r = '0;
      int c = ref_class();
      logic [7:0] pr = (c == 0) ? 8'd6 : 8'd17;
      m = '0;
      nbytes = 0;
      if (c == 4 || !tb_en[c]) return '0;
      if (c <= 1) begin
         if (pkt_v4) begin
            m = {pkt_src[31:0], pkt_dst[31:0], pkt_sport, pkt_dport, pr, 192'b0};
            nbytes = 13;
         end else begin
            m = {pkt_src, pkt_dst, pkt_sport, pkt_dport, pr};
            nbytes = 37;
         end
      end else if (c == 2) begin
         m = {pkt_src[31:0], pkt_dst[31:0], 232'b0};
         nbytes = 8;
      end else begin
         m = {pkt_src, pkt_dst, 40'b0};
         nbytes = 32;
      end
      for (int i = 0; i < nbytes * 8; i++)
         if (m[295-i])
            for (int k = 0; k < 32; k++)
               r[31-k] = r[31-k] ^ tb_key[319 - ((i + k) % 320)];
      return r;
   endfunction

   task automatic mirror(input logic [7:0] a, input logic [31:0] d);
      if (a < 8'd128) tb_tbl[a] = d[2:0];
      else if (a < 8'd138) tb_key[319 - 32*(a-128) -: 32] = d;
      else if (a == 8'd138) tb_en = d[3:0];
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      mirror(a, d);
   endtask

   task automatic set_pkt(input bit v4, input bit v6, input bit t, input bit u,
                          input logic [127:0] s, input logic [127:0] d,
                          input logic [15:0] sp, input logic [15:0] dp);
      pkt_v4 = v4; pkt_v6 = v6; pkt_tcp = t; pkt_udp = u;
      pkt_src = s; pkt_dst = d; pkt_sport = sp; pkt_dport = dp;
   endtask

   // Runs one packet; negedge n observes state after edge E(n), start taken at E0.
   task automatic run_pkt(input int wr_at, input logic [7:0] wa, input logic [31:0] wd,
                          input int poke_at);
      logic [127:0] keep_src = pkt_src;
      got_lat = -1; got_cnt = 0;
      @(negedge clk);
      pkt_start = 1'b1;
      @(posedge clk);
      for (int n = 0; n < 60; n++) begin
         @(negedge clk);
         if (sel_done) begin
            got_cnt++;
            if (got_lat < 0) begin
               got_lat = n; got_hash = sel_hash; got_q = sel_queue;
            end
         end
         pkt_start = (n == poke_at);
         pkt_src = (n == poke_at) ? ~keep_src : keep_src;
         cfg_we = (n == wr_at);
         cfg_addr = wa; cfg_wdata = wd;
         if (n == wr_at) mirror(wa, wd);
      end
      pkt_start = 1'b0; cfg_we = 1'b0; pkt_src = keep_src;
   endtask

   task automatic check_pkt(input string tag, input logic [2:0] exp_q_override, input bit use_override);
      int nb;
      logic [31:0] eh = ref_hash(nb);
      logic [2:0] eq = use_override ? exp_q_override : tb_tbl[eh[6:0]];
      int el = (nb == 0) ? 1 : nb + 1;
      chk(got_hash == eh, {tag, " hash"}, got_hash, eh);
      chk(got_q == eq, {tag, " queue"}, 32'(got_q), 32'(eq));
      chk(got_lat == el, {tag, " latency (R7)"}, got_lat, el);
      chk(got_cnt == 1, {tag, " one done pulse (R7)"}, got_cnt, 1);
   endtask

   // ---------- scenarios ----------
   task automatic t_reset();
      chk(sel_done == 1'b0, "R9 done after reset", 32'(sel_done), 0);
      chk(sel_hash == '0, "R9 hash after reset", sel_hash, 0);
      chk(sel_queue == '0, "R9 queue after reset", 32'(sel_queue), 0);
      set_pkt(0, 0, 1, 1, 128'h1234, 128'h5678, 16'h11, 16'h22);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R5 R9 unhashed packet", 0, 0);
   endtask

   task automatic t_program();
      for (int w = 0; w < 10; w++)
         cfg_write(8'(128 + w), 32'h6d5a56da ^ (32'h9e3779b9 * 32'(w + 1)));
      cfg_write(8'd138, 32'hF);
   endtask

   task automatic t_tcp4();
      set_pkt(1, 0, 1, 0, 128'hC0A80001, 128'h0A000002, 16'd443, 16'd51000);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R2 R4 R6 R9 tcp ipv4", 0, 0);
   endtask

   task automatic t_udp6();
      set_pkt(0, 1, 0, 1, 128'h20010db8_00000000_00000000_0000abcd,
              128'hfe800000_00000000_02112233_44556677, 16'd53, 16'd40000);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R2 R4 udp ipv6 key wrap", 0, 0);
   endtask

   task automatic t_other();
      set_pkt(1, 0, 0, 0, 128'h01020304, 128'hF0E0D0C0, 16'hFFFF, 16'h1111);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R3 other ipv4", 0, 0);
      set_pkt(0, 1, 0, 0, {4{32'hA5A55A5A}}, {4{32'h0F1E2D3C}}, 16'h2222, 16'h3333);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R3 other ipv6", 0, 0);
   endtask

   task automatic t_priority();
      set_pkt(1, 1, 1, 1, 128'hFFFF0000_11112222_33334444_0A0B0C0D,
              128'h99998888_77776666_55554444_01010101, 16'd80, 16'd8080);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R1 tcp over udp, ipv4 over ipv6", 0, 0);
   endtask

   task automatic t_disable();
      cfg_write(8'd0, 32'd5);
      cfg_write(8'd138, 32'b1101);
      set_pkt(1, 0, 0, 1, 128'hDEADBEEF, 128'hCAFEF00D, 16'd1, 16'd2);
      run_pkt(-1, 0, 0, -1);
      check_pkt("R5 udp disabled", 3'd5, 1);
      cfg_write(8'd138, 32'hF);
   endtask

   task automatic t_repeat();
      logic [31:0] h1; logic [2:0] q1;
      set_pkt(1, 0, 1, 0, 128'h0B0B0B0B, 128'h0C0C0C0C, 16'd1000, 16'd2000);
      run_pkt(-1, 0, 0, -1);
      h1 = got_hash; q1 = got_q;
      run_pkt(-1, 0, 0, -1);
      chk(got_hash == h1, "R12 same hash", got_hash, h1);
      chk(got_q == q1, "R12 same queue", 32'(got_q), 32'(q1));
   endtask

   task automatic t_busy();
      set_pkt(1, 0, 1, 0, 128'h11223344, 128'h55667788, 16'd7, 16'd9);
      run_pkt(-1, 0, 0, 3);
      check_pkt("R8 start while busy", 0, 0);
   endtask

   task automatic t_table_write();
      int nb;
      logic [31:0] eh;
      set_pkt(0, 1, 1, 0, 128'h1, 128'h2, 16'd3, 16'd4);
      eh = ref_hash(nb);
      cfg_write({1'b0, eh[6:0]}, 32'(3'(tb_tbl[eh[6:0]] + 3'd1)));
      run_pkt(-1, 0, 0, -1);
      check_pkt("R6 after table write", 0, 0);
   endtask

   task automatic t_collide();
      int nb;
      logic [31:0] eh;
      logic [2:0] oldq, newq;
      set_pkt(1, 0, 1, 0, 128'hAC100001, 128'hAC100002, 16'd5555, 16'd6666);
      eh = ref_hash(nb);
      oldq = tb_tbl[eh[6:0]];
      newq = oldq + 3'd3;
      // write on the lookup edge E14: not seen
      run_pkt(13, {1'b0, eh[6:0]}, 32'(newq), -1);
      check_pkt("R10 same-edge write", oldq, 1);
      // write one edge earlier (E13): seen
      oldq = tb_tbl[eh[6:0]];
      newq = oldq + 3'd2;
      run_pkt(12, {1'b0, eh[6:0]}, 32'(newq), -1);
      check_pkt("R10 earlier write", newq, 1);
      // unhashed packet: lookup at E1, entry 0 written on E1
      set_pkt(0, 0, 0, 0, 128'h0, 128'h0, 16'h0, 16'h0);
      oldq = tb_tbl[0];
      run_pkt(0, 8'd0, 32'(3'(oldq + 3'd1)), -1);
      check_pkt("R10 R5 same-edge write entry 0", oldq, 1);
   endtask

   task automatic t_unmapped();
      logic [31:0] h1;
      set_pkt(1, 0, 0, 1, 128'h0A0A0A0A, 128'h0B0B0B0B, 16'd10, 16'd20);
      run_pkt(-1, 0, 0, -1);
      h1 = got_hash;
      cfg_write(8'd139, 32'h0);
      cfg_write(8'd200, 32'hFFFFFFFF);
      cfg_write(8'd255, 32'h0);
      run_pkt(-1, 0, 0, -1);
      chk(got_hash == h1, "R11 unmapped writes ignored", got_hash, h1);
      check_pkt("R11 map after unmapped writes", 0, 0);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) tb_tbl[i] = 3'(i % 8);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_tcp4();
      t_udp6();
      t_other();
      t_priority();
      t_disable();
      t_repeat();
      t_busy();
      t_table_write();
      t_collide();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

endmodule